// File: doc/BRIEF.md
# Priority Pin Crossbar

This block connects a fixed set of peripheral signals to 32 general-purpose pins, which are grouped as four 8-bit ports. Software gives each peripheral group an enable bit. The enabled groups then take pins in a fixed priority order. Allocation starts at the lowest pin and moves upward, and any pin whose skip bit is set is passed over. A pin that no peripheral claims behaves as a plain GPIO: it drives its latch bit when its direction bit is set and stays high-impedance otherwise. The input side works the other way round: each peripheral input reads the pin that carries its signal.

Every control value sits in a small bank of registers written through a single-cycle write port. The mapping from configuration to pins is purely combinational. A write therefore shows on the pins in the cycle after the clock edge that accepts it. There is no data stream in this block, so every pin is a plain control or level signal.

The peripheral signal vector has 20 entries, in priority order: UART tx/rx (0-1), SPI sck/miso/mosi/nss (2-5), SMBus sda/scl (6-7), comparator 0 output (8), comparator 1 output (9), clock output (10), PCA channels 0-6 (11-17) and timer 0/1 inputs (18-19). These entries form eight groups, numbered 0 to 7 in the same order.

Top module: `pin_crossbar`

## Requirements
- R1: After reset, every configuration register is zero. No pin is driven, every peripheral input reads 1 and `alloc_ovf` is 0.
- R2: While the global enable (register 1 bit 7) is 0, no pin is driven and every peripheral input reads 1, whatever the other settings are.
- R3: While the global enable is 1, an unclaimed present pin drives its latch bit, and it drives only when its direction bit is 1.
- R4: Enabled groups take pins in group order 0 to 7. Within a group, the signals take pins in ascending signal order. The pins come from the non-skipped pins in ascending pin index, where pin index = port*8 + bit and allocation starts at index 0.
- R5: A pin whose skip bit is 1 is never claimed by a peripheral, and it behaves as GPIO.
- R6: The PCA group (group 6) claims as many pins as register 1 bits [2:0] give, from 0 to 7. It uses its lowest-numbered signals first. A count of 0 claims nothing and never counts as overflow.
- R7: A group that needs more pins than remain gets none, and every lower-priority group gets none too. `alloc_ovf` is 1 exactly when some enabled group with a nonzero size is refused. Refused signals leave their pins as GPIO.
- R8: A peripheral input whose signal holds a pin reads that pin's input, provided the global enable is 1. Otherwise it reads 1.
- R9: When parameter `HAS_P3_HI` is 0, pins 29 to 31 count as skipped and are never driven.
- R10: Register addresses are as follows. 0 holds the group enables (bit k enables group k). 1 holds the PCA count in [2:0] and the global enable in bit 7. 2 to 5 hold the skip masks for ports 0 to 3, 6 to 9 the latches, and 10 to 13 the directions. A write to any other address changes nothing.
- R11: A claimed pin drives the value and output enable of its peripheral signal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 8 | Register write data |
| per_o | input | 20 | Peripheral output values |
| per_oe | input | 20 | Peripheral output enables |
| per_i | output | 20 | Peripheral inputs routed from pins |
| pin_i | input | 32 | Pin input levels |
| pin_o | output | 32 | Pin output values |
| pin_oe | output | 32 | Pin output enables (0 = high-impedance) |
| alloc_ovf | output | 1 | Some enabled group could not be placed |

## Verification
The assertions assume that reset is applied before any write. They also assume that `cfg_addr` and `cfg_wdata` hold known values whenever `cfg_we` is 1, and that the pin and peripheral inputs never carry unknown values. The stimulus applies reset first and drives every input to a defined value from time zero. It changes inputs only at falling edges or just after rising edges, so a write and a pin sample never fall on the same edge.

// File: rtl/pxb_pkg.sv
package pxb_pkg;
  localparam int NGRP    = 8;
  localparam int PCA_GRP = 6;
  // maximum pin count of each group, highest priority first
  localparam int GRP_MAX [NGRP] = '{2, 4, 2, 1, 1, 1, 7, 2};

  function automatic int grp_base(int g);
    int b;
    b = 0;
    for (int k = 0; k < NGRP; k++) if (k < g) b += GRP_MAX[k];
    return b;
  endfunction

  localparam int NSIG = grp_base(NGRP);

  function automatic int sig_grp(int s);
    int g;
    g = 0;
    for (int k = 0; k < NGRP; k++) if (s >= grp_base(k)) g = k;
    return g;
  endfunction

  localparam int ADR_EN    = 0;
  localparam int ADR_CTRL  = 1;
  localparam int ADR_SKIP0 = 2;
endpackage

// File: rtl/pxb_cfg.sv
module pxb_cfg
  import pxb_pkg::*;
#(
  parameter int NPORT = 4,
  parameter int PW    = 8,
  parameter int AW    = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [AW-1:0]         addr,
  input  logic [PW-1:0]         wdata,
  output logic [NGRP-1:0]       grp_en,
  output logic [2:0]            pca_cnt,
  output logic                  xbar_on,
  output logic [NPORT*PW-1:0]   skip,
  output logic [NPORT*PW-1:0]   latch,
  output logic [NPORT*PW-1:0]   dir
);
  localparam int LATCH0 = ADR_SKIP0 + NPORT;
  localparam int DIR0   = ADR_SKIP0 + 2*NPORT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_en  <= '0;
      pca_cnt <= '0;
      xbar_on <= 1'b0;
      skip    <= '0;
      latch   <= '0;
      dir     <= '0;
    end else if (we) begin
      if (addr == AW'(ADR_EN))   grp_en <= wdata[NGRP-1:0];
      if (addr == AW'(ADR_CTRL)) begin
        pca_cnt <= wdata[2:0];
        xbar_on <= wdata[PW-1];
      end
      for (int i = 0; i < NPORT; i++) begin
        if (addr == AW'(ADR_SKIP0 + i)) skip[i*PW +: PW]  <= wdata;
        if (addr == AW'(LATCH0 + i))    latch[i*PW +: PW] <= wdata;
        if (addr == AW'(DIR0 + i))      dir[i*PW +: PW]   <= wdata;
      end
    end
  end

  // R10: register writes land on the following edge
  a_r10_skip_write: assert property (@(posedge clk) disable iff (!rst_n)
    we && addr == AW'(ADR_SKIP0) |=> skip[PW-1:0] == $past(wdata));
  a_r10_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
    we && addr == AW'(ADR_CTRL) |=> xbar_on == $past(wdata[PW-1]));
endmodule

// File: rtl/pxb_alloc.sv
module pxb_alloc
  import pxb_pkg::*;
#(
  parameter int NPIN = 32
) (
  input  logic [NGRP-1:0]          grp_en,
  input  logic [2:0]               pca_cnt,
  input  logic [NPIN-1:0]          skip,
  output logic [NPIN-1:0]          pin_hit,
  output logic [$clog2(NSIG)-1:0]  pin_sig [NPIN],
  output logic [NSIG-1:0]          sig_hit,
  output logic [$clog2(NPIN)-1:0]  sig_pin [NSIG],
  output logic                     ovf
);
  localparam int CW = $clog2(NPIN + 1);

  logic [NGRP-1:0] grant;
  int              gsz   [NGRP];
  logic [CW-1:0]   srank [NSIG];
  logic [CW-1:0]   prank [NPIN];

  // group admission in priority order; first refusal blocks the rest
  always_comb begin
    int nfree, used;
    logic fail;
    nfree = 0;
    for (int p = 0; p < NPIN; p++) if (!skip[p]) nfree++;
    used  = 0;
    fail  = 1'b0;
    ovf   = 1'b0;
    grant = '0;
    for (int g = 0; g < NGRP; g++) begin
      gsz[g] = (g == PCA_GRP) ? int'(pca_cnt) : GRP_MAX[g];
      if (grp_en[g] && gsz[g] > 0) begin
        if (!fail && used + gsz[g] <= nfree) begin
          grant[g] = 1'b1;
          used += gsz[g];
        end else begin
          fail = 1'b1;
          ovf  = 1'b1;
        end
      end
    end
  end

  // ranks: position among admitted signals and among free pins
  always_comb begin
    int rs, rp;
    rs = 0;
    for (int s = 0; s < NSIG; s++) begin
      sig_hit[s] = grant[sig_grp(s)] && (s - grp_base(sig_grp(s)) < gsz[sig_grp(s)]);
      srank[s]   = CW'(rs);
      if (sig_hit[s]) rs++;
    end
    rp = 0;
    for (int p = 0; p < NPIN; p++) begin
      prank[p] = CW'(rp);
      if (!skip[p]) rp++;
    end
  end

  // rank match pairs each admitted signal with one free pin
  always_comb begin
    for (int s = 0; s < NSIG; s++) sig_pin[s] = '0;
    for (int p = 0; p < NPIN; p++) begin
      pin_hit[p] = 1'b0;
      pin_sig[p] = '0;
      for (int s = 0; s < NSIG; s++) begin
        if (sig_hit[s] && !skip[p] && srank[s] == prank[p]) begin
          pin_hit[p] = 1'b1;
          pin_sig[p] = ($clog2(NSIG))'(s);
          sig_pin[s] = ($clog2(NPIN))'(p);
        end
      end
    end
  end
endmodule

// File: rtl/pxb_route.sv
module pxb_route
  import pxb_pkg::*;
#(
  parameter int NPIN = 32
) (
  input  logic                     xbar_on,
  input  logic [NPIN-1:0]          absent,
  input  logic [NPIN-1:0]          pin_hit,
  input  logic [$clog2(NSIG)-1:0]  pin_sig [NPIN],
  input  logic [NSIG-1:0]          sig_hit,
  input  logic [$clog2(NPIN)-1:0]  sig_pin [NSIG],
  input  logic [NPIN-1:0]          latch,
  input  logic [NPIN-1:0]          dir,
  input  logic [NSIG-1:0]          per_o,
  input  logic [NSIG-1:0]          per_oe,
  input  logic [NPIN-1:0]          pin_i,
  output logic [NPIN-1:0]          pin_o,
  output logic [NPIN-1:0]          pin_oe,
  output logic [NSIG-1:0]          per_i
);
  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    always_comb begin
      pin_o[p]  = pin_hit[p] ? per_o[pin_sig[p]] : latch[p];
      pin_oe[p] = xbar_on && !absent[p] && (pin_hit[p] ? per_oe[pin_sig[p]] : dir[p]);
    end
  end

  for (genvar s = 0; s < NSIG; s++) begin : g_sig
    assign per_i[s] = (xbar_on && sig_hit[s]) ? pin_i[sig_pin[s]] : 1'b1;
  end
endmodule

// File: rtl/pin_crossbar.sv
module pin_crossbar
  import pxb_pkg::*;
#(
  parameter int NPORT     = 4,
  parameter int PW        = 8,
  parameter int AW        = 4,
  parameter bit HAS_P3_HI = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [AW-1:0]         cfg_addr,
  input  logic [PW-1:0]         cfg_wdata,
  input  logic [NSIG-1:0]       per_o,
  input  logic [NSIG-1:0]       per_oe,
  output logic [NSIG-1:0]       per_i,
  input  logic [NPORT*PW-1:0]   pin_i,
  output logic [NPORT*PW-1:0]   pin_o,
  output logic [NPORT*PW-1:0]   pin_oe,
  output logic                  alloc_ovf
);
  localparam int NPIN = NPORT * PW;
  localparam logic [NPIN-1:0] ABSENT =
    HAS_P3_HI ? '0 : {3'b111, {(NPIN-3){1'b0}}};

  logic [NGRP-1:0]          grp_en;
  logic [2:0]               pca_cnt;
  logic                     xbar_on;
  logic [NPIN-1:0]          skip, skip_eff, latch, dir, pin_hit;
  logic [$clog2(NSIG)-1:0]  pin_sig [NPIN];
  logic [NSIG-1:0]          sig_hit;
  logic [$clog2(NPIN)-1:0]  sig_pin [NSIG];

  assign skip_eff = skip | ABSENT;

  pxb_cfg #(.NPORT(NPORT), .PW(PW), .AW(AW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .grp_en(grp_en), .pca_cnt(pca_cnt), .xbar_on(xbar_on),
    .skip(skip), .latch(latch), .dir(dir));

  pxb_alloc #(.NPIN(NPIN)) u_alloc (
    .grp_en(grp_en), .pca_cnt(pca_cnt), .skip(skip_eff),
    .pin_hit(pin_hit), .pin_sig(pin_sig), .sig_hit(sig_hit),
    .sig_pin(sig_pin), .ovf(alloc_ovf));

  pxb_route #(.NPIN(NPIN)) u_route (
    .xbar_on(xbar_on), .absent(ABSENT), .pin_hit(pin_hit), .pin_sig(pin_sig),
    .sig_hit(sig_hit), .sig_pin(sig_pin), .latch(latch), .dir(dir),
    .per_o(per_o), .per_oe(per_oe), .pin_i(pin_i),
    .pin_o(pin_o), .pin_oe(pin_oe), .per_i(per_i));

  a_r2_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !xbar_on |-> (pin_oe == '0) && (per_i == '1));
  a_r5_skip_unclaimed: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_hit & skip_eff) == '0);
  a_r9_absent_undriven: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & ABSENT) == '0);
  a_r4_one_to_one: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(pin_hit) == $countones(sig_hit));
  a_r6_pca_bound: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(sig_hit[grp_base(PCA_GRP) +: GRP_MAX[PCA_GRP]]) <= int'(pca_cnt));
  a_r7_ovf_clear_all_fit: assert property (@(posedge clk) disable iff (!rst_n)
    grp_en == '0 |-> !alloc_ovf);
endmodule

// File: tb/pin_crossbar_bench.sv
module pin_crossbar_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NSIG = 20;
  localparam int NPIN = 32;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic            rst_n = 1'b0;
  logic            cfg_we = 1'b0;
  logic [3:0]      cfg_addr = '0;
  logic [7:0]      cfg_wdata = '0;
  logic [NSIG-1:0] per_o = '0, per_oe = '0;
  logic [NPIN-1:0] pin_i = '0;
  logic [NSIG-1:0] per_i_f, per_i_l;
  logic [NPIN-1:0] pin_o_f, pin_oe_f, pin_o_l, pin_oe_l;
  logic            ovf_f, ovf_l;

  pin_crossbar u_pin_crossbar (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .per_o(per_o), .per_oe(per_oe), .per_i(per_i_f),
    .pin_i(pin_i), .pin_o(pin_o_f), .pin_oe(pin_oe_f), .alloc_ovf(ovf_f));

  pin_crossbar #(.HAS_P3_HI(1'b0)) u_pin_crossbar_lite (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .per_o(per_o), .per_oe(per_oe), .per_i(per_i_l),
    .pin_i(pin_i), .pin_o(pin_o_l), .pin_oe(pin_oe_l), .alloc_ovf(ovf_l));

  int checks = 0;
  int errors = 0;

  // bench shadow of the register map (R10)
  logic [7:0]      m_en = '0;
  logic [2:0]      m_pca = '0;
  logic            m_on = 1'b0;
  logic [NPIN-1:0] m_skip = '0, m_latch = '0, m_dir = '0;

  typedef struct {
    string req; bit lite;
    logic [NPIN-1:0] oe; logic [NPIN-1:0] o; logic [NSIG-1:0] pi; logic ovf;
  } exp_t;
  exp_t q[$];

  function automatic exp_t model(bit lite, string req);
    exp_t e;
    int wmax [8] = '{2, 4, 2, 1, 1, 1, 7, 2};
    int gsz  [8];
    int free_l [NPIN];
    int sigpin [NSIG];
    int pinsig [NPIN];
    int nf, nxt, b;
    bit fail;
    logic [NPIN-1:0] sk;
    e.req = req; e.lite = lite; e.ovf = 1'b0;
    sk = m_skip | (lite ? 32'hE000_0000 : 32'h0);
    nf = 0;
    for (int p = 0; p < NPIN; p++) begin
      pinsig[p] = -1;
      if (!sk[p]) begin free_l[nf] = p; nf++; end
    end
    for (int s = 0; s < NSIG; s++) sigpin[s] = -1;
    for (int g = 0; g < 8; g++) gsz[g] = (g == 6) ? int'(m_pca) : wmax[g];
    nxt = 0; fail = 1'b0; b = 0;
    for (int g = 0; g < 8; g++) begin
      if (m_en[g] && gsz[g] > 0) begin
        if (fail || nxt + gsz[g] > nf) begin
          fail = 1'b1; e.ovf = 1'b1;
        end else begin
          for (int j = 0; j < gsz[g]; j++) begin
            sigpin[b+j] = free_l[nxt+j];
            pinsig[free_l[nxt+j]] = b + j;
          end
          nxt += gsz[g];
        end
      end
      b += wmax[g];
    end
    for (int p = 0; p < NPIN; p++) begin
      if (pinsig[p] >= 0) begin
        e.o[p]  = per_o[pinsig[p]];
        e.oe[p] = per_oe[pinsig[p]];
      end else begin
        e.o[p]  = m_latch[p];
        e.oe[p] = m_dir[p];
      end
      if (!m_on || (lite && p >= 29)) e.oe[p] = 1'b0;
    end
    for (int s = 0; s < NSIG; s++)
      e.pi[s] = (m_on && sigpin[s] >= 0) ? pin_i[sigpin[s]] : 1'b1;
    return e;
  endfunction

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (a == 0) m_en = d;
    else if (a == 1) begin m_pca = d[2:0]; m_on = d[7]; end
    else if (a >= 2 && a <= 5) m_skip[(a-2)*8 +: 8] = d;
    else if (a >= 6 && a <= 9) m_latch[(a-6)*8 +: 8] = d;
    else if (a >= 10 && a <= 13) m_dir[(a-10)*8 +: 8] = d;
  endtask

  task automatic wr_ports(input int base, input logic [31:0] v);
    for (int i = 0; i < 4; i++) wr(base + i, v[i*8 +: 8]);
  endtask

  // driver: push expected snapshots for both variants, wait for the monitor
  task automatic expect_now(input string req);
    @(posedge clk); #1;
    q.push_back(model(1'b0, req));
    q.push_back(model(1'b1, req));
    while (q.size() != 0) @(posedge clk);
  endtask

  task automatic cmp(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        if (!e.lite) begin
          cmp(e.req, "pin_oe", pin_oe_f, e.oe);
          cmp(e.req, "pin_o", pin_o_f & e.oe, e.o & e.oe);
          cmp(e.req, "per_i", 32'(per_i_f), 32'(e.pi));
          cmp(e.req, "ovf", 32'(ovf_f), 32'(e.ovf));
        end else begin
          cmp(e.req, "lite pin_oe", pin_oe_l, e.oe);
          cmp(e.req, "lite pin_o", pin_o_l & e.oe, e.o & e.oe);
          cmp(e.req, "lite per_i", 32'(per_i_l), 32'(e.pi));
          cmp(e.req, "lite ovf", 32'(ovf_l), 32'(e.ovf));
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1: reset state
    expect_now("R1");

    // R2: global enable off hides everything
    wr(0, 8'hFF); wr(1, 8'h07); wr_ports(10, 32'hFFFF_FFFF);
    per_o = 20'hA5C3B; per_oe = 20'hFFFFF;
    expect_now("R2");

    // R4/R11: all groups, no skips, priority order from pin 0
    wr_ports(6, 32'h8100_5A3C); wr(1, 8'h87);
    expect_now("R4");
    per_o = 20'h5A3C4; per_oe = 20'h0F0F3;
    expect_now("R11");

    // R3: pure GPIO
    wr(0, 8'h00); wr_ports(6, 32'h81F0_3C5A); wr_ports(10, 32'hAA00_FF0F);
    expect_now("R3");

    // R5: skipped pins passed over
    wr(0, 8'h05); wr(2, 8'h05); wr_ports(10, 32'hFFFF_FFFF);
    expect_now("R5");

    // R8: input routing
    per_oe = '0; pin_i = 32'h1234_56A9;
    expect_now("R8");
    pin_i = 32'hEDCB_A956;
    expect_now("R8");

    // R6: PCA count 3 then 0
    per_oe = 20'hFFFFF; wr(2, 8'h00); wr(0, 8'h40); wr(1, 8'h83);
    expect_now("R6");
    wr(1, 8'h80);
    expect_now("R6");

    // R7: overflow with only port 3 free; R9 via the reduced variant
    wr(0, 8'hFF); wr(1, 8'h87); wr(2, 8'hFF); wr(3, 8'hFF); wr(4, 8'hFF);
    expect_now("R7");
    wr(5, 8'h03);
    expect_now("R7");

    // R9: upper port 3 pins absent in the reduced variant
    wr_ports(2, 32'h0); wr(0, 8'h00);
    expect_now("R9");

    // R10: unmapped addresses change nothing
    wr(14, 8'hFF); wr(15, 8'h00);
    expect_now("R10");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule